// File: doc/BRIEF.md
# Column Driver Line Loader

This block takes one display line of pixel bits for a column (segment) driver and holds it for the output stage. Pixel data arrives on an 8-bit bus, one transfer per shift clock. A width select chooses full-byte transfers or half-byte transfers. In half-byte mode, two successive nibbles are joined into one byte, with the first nibble in the lower half. A write pointer advances only while the cascade enable input is high. When the line is full, the pointer stops, further bus traffic is ignored, and an enable is raised towards the next device in the chain.

A direction select chooses whether filling starts at output 0 or at output LINE_W-1. The same select also swaps the roles of the two cascade enable pins. A line pulse copies the filled line into the output latch, records the frame-reversal input beside it, and rearms the pointer for the next line. A blanking input forces every output to the deselect level (0) without disturbing the latch.

Top module: `seg_line_loader`

## Requirements
- R1: After reset, every column output, both cascade enable outputs and the latched frame-reversal output are 0.
- R2: With wide_mode=1 and rev_dir=0, each accepted transfer writes one byte. Bit i of the k-th accepted byte lands on column 8k+i. LINE_W/8 transfers fill the line.
- R3: With wide_mode=0, only din[3:0] is used. The first accepted nibble supplies bits 0..3 of a byte and the second nibble supplies bits 4..7. LINE_W/4 transfers fill the line.
- R4: With rev_dir=1, stream bit k (counted over the bytes as in R2/R3) lands on column LINE_W-1-k. In this direction pin A is the cascade output (en_a_oe=1, en_b_oe=0) and en_b_i is the enable input. With rev_dir=0 the roles are the other way round.
- R5: A transfer is accepted only on a clock where the enable input of the current direction is 1. Clocks with that enable at 0 change nothing.
- R6: Once LINE_W bits have been accepted, further transfers are ignored until the next line pulse.
- R7: The cascade output of the current direction goes to 1 on the clock edge that accepts the final transfer, so it is seen in the following cycle. It stays at 1 until a line pulse. The other enable output stays 0.
- R8: On a line pulse, the loaded line appears on the column outputs in the following cycle, the pointer rearms and the cascade output returns to 0. A transfer offered in the pulse cycle is ignored. The outputs do not change between line pulses.
- R9: While disp_off=1, all column outputs read 0. When disp_off returns to 0, the latched line reappears unchanged.
- R10: line_fr presents the value that frame_rev had at the last line pulse. frame_rev has no effect on loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode | input | 1 | 1: byte transfers, 0: nibble transfers |
| rev_dir | input | 1 | 0: fill from column 0, 1: fill from column LINE_W-1 |
| din | input | 8 | Pixel data bus |
| en_a_i | input | 1 | Cascade enable in, pin A (used when rev_dir=0) |
| en_a_o | output | 1 | Cascade enable out, pin A (driven when rev_dir=1) |
| en_a_oe | output | 1 | Pin A output enable |
| en_b_i | input | 1 | Cascade enable in, pin B (used when rev_dir=1) |
| en_b_o | output | 1 | Cascade enable out, pin B (driven when rev_dir=0) |
| en_b_oe | output | 1 | Pin B output enable |
| latch_pulse | input | 1 | Line pulse: latch the line and rearm the loader |
| disp_off | input | 1 | Force all columns to deselect level |
| frame_rev | input | 1 | Frame-reversal bit captured at the line pulse |
| seg_out | output | LINE_W | Latched column data |
| line_fr | output | 1 | Frame-reversal bit of the latched line |

## Verification
The bench builds the block with its default LINE_W of 240. This makes full lines of 30 byte transfers and 60 nibble transfers reachable, together with the exact final group where the cascade enable rises and the stop takes effect. Both fill directions are run in both widths. The runs include enable gaps in the middle of a line, junk in the unused upper nibble, extra transfers after the line is full, and a transfer offered during the line pulse. The offered transfer would misplace the whole next line if it were accepted.

// File: rtl/seg_line_loader.sv
module seg_line_loader #(
  parameter int LINE_W = 240,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              rev_dir,
  input  logic [BUS_W-1:0]  din,
  input  logic              en_a_i,
  output logic              en_a_o,
  output logic              en_a_oe,
  input  logic              en_b_i,
  output logic              en_b_o,
  output logic              en_b_oe,
  input  logic              latch_pulse,
  input  logic              disp_off,
  input  logic              frame_rev,
  output logic [LINE_W-1:0] seg_out,
  output logic              line_fr
);
  localparam int GROUPS = LINE_W / BUS_W;
  localparam int GW     = $clog2(GROUPS);
  localparam int NIB    = BUS_W / 2;

  logic [GW-1:0]     grp_q;
  logic              half_q;
  logic [NIB-1:0]    nib_q;
  logic              done_q;
  logic [LINE_W-1:0] sr_q;
  logic [LINE_W-1:0] line_q;
  logic              fr_q;
  logic [BUS_W-1:0]  word_fwd;
  logic [BUS_W-1:0]  word_rev;
  int                fwd_base;
  int                rev_base;

  wire en_in  = rev_dir ? en_b_i : en_a_i;
  wire take   = en_in & ~done_q & ~latch_pulse;
  wire commit = take & (wide_mode | half_q);
  wire last   = (grp_q == GW'(GROUPS - 1));

  assign word_fwd = wide_mode ? din : {din[NIB-1:0], nib_q};

  for (genvar i = 0; i < BUS_W; i++) begin : g_rev
    assign word_rev[i] = word_fwd[BUS_W-1-i];
  end

  always_comb begin
    fwd_base = int'(grp_q) * BUS_W;
    rev_base = LINE_W - BUS_W - fwd_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= '0;
    else if (commit) begin
      if (rev_dir) sr_q[rev_base +: BUS_W] <= word_rev;
      else         sr_q[fwd_base +: BUS_W] <= word_fwd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      half_q <= 1'b0;
      nib_q  <= '0;
      done_q <= 1'b0;
      line_q <= '0;
      fr_q   <= 1'b0;
    end else if (latch_pulse) begin
      grp_q  <= '0;
      half_q <= 1'b0;
      done_q <= 1'b0;
      line_q <= sr_q;
      fr_q   <= frame_rev;
    end else if (take) begin
      if (!wide_mode && !half_q) begin
        nib_q  <= din[NIB-1:0];
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
        if (last) done_q <= 1'b1;
        else      grp_q  <= grp_q + 1'b1;
      end
    end
  end

  assign en_a_oe = rev_dir;
  assign en_b_oe = ~rev_dir;
  assign en_a_o  = rev_dir & done_q;
  assign en_b_o  = ~rev_dir & done_q;
  assign seg_out = disp_off ? '0 : line_q;
  assign line_fr = fr_q;
endmodule

// File: rtl/seg_line_loader_chk.sv
module seg_line_loader_chk #(
  parameter int LINE_W = 240
) (
  input logic              clk,
  input logic              rst_n,
  input logic              latch_pulse,
  input logic              disp_off,
  input logic              frame_rev,
  input logic              en_a_o,
  input logic              en_b_o,
  input logic              en_a_oe,
  input logic              en_b_oe,
  input logic [LINE_W-1:0] seg_out,
  input logic              line_fr,
  input logic              done_q,
  input logic [LINE_W-1:0] sr_q
);
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !latch_pulse) |=> ($stable(sr_q) && done_q));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_a_o || en_b_o) && !latch_pulse) |=> (en_a_o || en_b_o));

  a_r4_pin_roles: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({en_a_oe, en_b_oe}) == 1) && (!en_a_o || en_a_oe) && (!en_b_o || en_b_oe));

  a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |=> (!en_a_o && !en_b_o));

  a_r8_copy: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |=> (disp_off || seg_out == $past(sr_q)));

  a_r9_blank: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off |-> (seg_out == '0));

  a_r10_fr: assert property (@(posedge clk) disable iff (!rst_n)
    latch_pulse |=> (line_fr == $past(frame_rev)));
endmodule

bind seg_line_loader seg_line_loader_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .latch_pulse(latch_pulse), .disp_off(disp_off),
  .frame_rev(frame_rev), .en_a_o(en_a_o), .en_b_o(en_b_o), .en_a_oe(en_a_oe),
  .en_b_oe(en_b_oe), .seg_out(seg_out), .line_fr(line_fr), .done_q(done_q),
  .sr_q(sr_q)
);

// File: tb/test_seg_line_loader.sv
module test_seg_line_loader;
  localparam int LINE_W = 240;
  localparam int GROUPS = LINE_W / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b1, rev_dir = 1'b0;
  logic [7:0] din = '0;
  logic en_a_i = 1'b0, en_b_i = 1'b0;
  logic en_a_o, en_a_oe, en_b_o, en_b_oe;
  logic latch_pulse = 1'b0, disp_off = 1'b0, frame_rev = 1'b0;
  logic [LINE_W-1:0] seg_out;
  logic line_fr;

  int n_chk = 0, n_fail = 0;
  logic [LINE_W-1:0] exp_line_q[$];
  logic exp_fr_q[$];
  string tag_q[$];
  logic [LINE_W-1:0] shown = '0;
  event mon_ev;

  always #5 clk = ~clk;

  seg_line_loader #(.LINE_W(LINE_W)) i_seg_line_loader (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .rev_dir(rev_dir), .din(din),
    .en_a_i(en_a_i), .en_a_o(en_a_o), .en_a_oe(en_a_oe),
    .en_b_i(en_b_i), .en_b_o(en_b_o), .en_b_oe(en_b_oe),
    .latch_pulse(latch_pulse), .disp_off(disp_off), .frame_rev(frame_rev),
    .seg_out(seg_out), .line_fr(line_fr)
  );

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk_vec(input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int k);
    return 8'((k * 29) + (seed * 71) + (k * k * 3) + 5);
  endfunction

  task automatic set_en(input logic v);
    en_a_i = rev_dir ? 1'b0 : v;
    en_b_i = rev_dir ? v : 1'b0;
  endtask

  function automatic logic casc();
    return rev_dir ? en_a_o : en_b_o;
  endfunction

  task automatic xfer(input logic [7:0] d);
    @(negedge clk);
    din = d;
    set_en(1'b1);
  endtask

  // Loads one full line; returns the expected column image.
  task automatic load_line(input logic wide, input logic rev, input int seed,
                           input logic gap, output logic [LINE_W-1:0] exp);
    logic [7:0] b;
    @(negedge clk);
    wide_mode = wide;
    rev_dir = rev;
    set_en(1'b0);
    exp = '0;
    for (int g = 0; g < GROUPS; g++) begin
      b = byte_of(seed, g);
      for (int i = 0; i < 8; i++) begin
        if (rev) exp[LINE_W-1-(8*g+i)] = b[i];
        else     exp[8*g+i] = b[i];
      end
      if (g == GROUPS - 1) chk_bit(casc(), 1'b0, "R7 cascade low before final transfer");
      if (wide) xfer(b);
      else begin
        xfer({~b[3:0], b[3:0]});
        xfer({b[3:0], b[7:4]});
      end
      if (gap && g == 10) begin
        for (int j = 0; j < 3; j++) begin
          @(negedge clk);
          set_en(1'b0);
          din = 8'hA5;
        end
      end
    end
    @(negedge clk);
    set_en(1'b0);
    chk_bit(casc(), 1'b1, rev ? "R4/R7 cascade out on pin A" : "R7 cascade out on pin B");
    chk_bit(rev ? en_b_o : en_a_o, 1'b0, "R7 non-output pin stays low");
    chk_bit(en_a_oe, rev, "R4 pin A direction");
    for (int j = 0; j < 4; j++) xfer(8'h5A);
    @(negedge clk);
    set_en(1'b0);
    chk_bit(casc(), 1'b1, "R6/R7 cascade held after extra transfers");
    chk_vec(seg_out, shown, "R8 outputs unchanged before line pulse");
  endtask

  task automatic pulse(input logic fr, input logic offer, input logic [LINE_W-1:0] exp, input string tag);
    @(negedge clk);
    latch_pulse = 1'b1;
    frame_rev = fr;
    din = 8'hFF;
    set_en(offer);
    @(negedge clk);
    latch_pulse = 1'b0;
    set_en(1'b0);
    frame_rev = ~fr;
    exp_line_q.push_back(exp);
    exp_fr_q.push_back(fr);
    tag_q.push_back(tag);
    shown = exp;
    ->mon_ev;
  endtask

  initial begin : monitor
    forever begin
      @(mon_ev);
      while (exp_line_q.size() > 0) begin
        chk_vec(seg_out, exp_line_q.pop_front(), tag_q[0]);
        chk_bit(line_fr, exp_fr_q.pop_front(), "R10 frame bit latched");
        chk_bit(en_a_o | en_b_o, 1'b0, "R8 cascade cleared by line pulse");
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin : watchdog
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [LINE_W-1:0] e;
    #23 rst_n = 1'b1;
    @(negedge clk);
    chk_vec(seg_out, '0, "R1 columns after reset");
    chk_bit(en_a_o | en_b_o, 1'b0, "R1 cascade outputs after reset");
    chk_bit(line_fr, 1'b0, "R1 frame bit after reset");

    load_line(1'b1, 1'b0, 1, 1'b1, e);
    pulse(1'b1, 1'b0, e, "R2/R5 byte mode forward line");
    load_line(1'b0, 1'b0, 2, 1'b1, e);
    pulse(1'b0, 1'b1, e, "R3 nibble mode forward line");
    load_line(1'b1, 1'b0, 3, 1'b0, e);
    pulse(1'b1, 1'b0, e, "R8 line after offered transfer in pulse cycle");
    load_line(1'b1, 1'b1, 4, 1'b0, e);
    pulse(1'b0, 1'b1, e, "R4 byte mode reverse line");
    load_line(1'b0, 1'b1, 5, 1'b1, e);
    pulse(1'b1, 1'b0, e, "R4/R3 nibble mode reverse line");

    @(negedge clk);
    disp_off = 1'b1;
    @(negedge clk);
    chk_vec(seg_out, '0, "R9 blanked columns");
    disp_off = 1'b0;
    @(negedge clk);
    chk_vec(seg_out, e, "R9 line restored after blanking");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule